// File: doc/BRIEF.md
# Pulse-Position Nibble Decoder

This block recovers 4-bit values from the read-data line of a magnetic disk drive whose track carries pulse-position symbols. Each symbol opens with a rising edge. A falling edge follows after a fixed lead time plus a data-dependent offset. The delay between these two edges, counted in clock ticks, encodes the nibble. After the falling edge comes a quiet gap. The gap must be at least a minimum length, but it may be longer. Because of this, symbols written in separate passes still decode.

The read line passes through a two-stage synchroniser and a filter that removes single-tick pulses. After that, rising and falling edges are detected. Every rising edge clears the interval counter and starts a new measurement, so no bit-clock recovery loop is needed. For each symbol the block gives exactly one outcome on one-cycle pulses: a valid nibble, a range error, or a timeout. A gap that is too short is flagged on its own pulse when the next start edge arrives.

The clock is the tick clock, 16 MHz in the intended use. With the default parameters the lead time is 32 ticks (2 µs), the value window is 16 ticks (1 µs), the minimum gap is 32 ticks and the timeout is 64 ticks (4 µs).

Top module: `ppm_nibble_decoder`

## Requirements
Timing terms used below:
- Edge a is the first clock edge at which `rd_in` is sampled high for a symbol.
- D is the number of consecutive edges on which it stays high.
- The falling edge is therefore first sampled low at edge a+D.
- A result is "due at edge n" when it is visible for the one cycle that follows clock edge n.

- R1: While `rst` is high, and after its release while `rd_in` stays low, `nib_valid`, `err_range`, `err_timeout`, `err_spacing` and `nib_data` are all 0.
- R2: When 32 ≤ D ≤ 47, `nib_valid` pulses at edge a+D+4 and `nib_data` = D−32, with bit 3 as the most significant bit. `nib_data` keeps its last value until the next valid nibble.
- R3: When D < 32, or 48 ≤ D ≤ 64, `err_range` pulses at edge a+D+4 and `nib_valid` stays low.
- R4: When D > 64, `err_timeout` pulses at edge a+68 and no other result is given for that symbol. The decoder then waits for the next rising edge, and that rising edge is not checked for spacing.
- R5: Take a symbol that ended with a falling edge (R2 or R3) and is followed by a low gap of L sampled edges. If L < 32, `err_spacing` pulses at edge a'+4, where a' is the next symbol's start edge. That next symbol is still measured and decoded normally.
- R6: A low gap of 32 or more edges, of any length, causes no error, and decoding continues symbol after symbol.
- R7: A level held for a single sampled edge is ignored. This covers a one-tick high pulse on an idle line and a one-tick low dip inside a symbol's high time.
- R8: The four result strobes are one-cycle pulses. At most one of them is high in any cycle, and none is raised except as listed in R2 to R5.
- R9: The first symbol after reset never raises `err_spacing`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_in | input | 1 | Asynchronous read-data line from the drive |
| nib_valid | output | 1 | One-cycle strobe: `nib_data` holds a new nibble |
| nib_data | output | 4 | Last decoded nibble |
| err_range | output | 1 | One-cycle strobe: measured delay outside the value window |
| err_timeout | output | 1 | One-cycle strobe: no value edge within the timeout |
| err_spacing | output | 1 | One-cycle strobe: start edge came too soon after a value edge |

## Verification
Every input edge reaches the symbol timer four clock edges after it is first sampled. The delays are two synchroniser stages, one filter stage and one edge-detect stage. As a result, a symbol's outcome is due at edge a+D+4, a timeout at edge a+68, and a spacing error four edges after the offending start edge. The bench drives `rd_in` on falling clock edges and records the edge index a at which each symbol is first sampled. From the D and L values it chose, it computes the cycle in which each pulse is due. On every falling edge it compares all strobes and `nib_data` against that schedule, so a pulse that arrives one cycle early or late is reported.

// File: rtl/ppmdec_pkg.sv
package ppmdec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEAS,
        ST_GAP
    } sym_state_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_NIBBLE,
        EV_RANGE,
        EV_TIMEOUT,
        EV_SPACING
    } sym_event_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_info_t;

    typedef struct packed {
        sym_event_e ev;
        logic [3:0] nib;
    } sym_result_t;

    function automatic logic count_in_window(input int unsigned cnt,
                                             input int unsigned lo,
                                             input int unsigned span);
        return (cnt >= lo) && (cnt < lo + span);
    endfunction

endpackage

// File: rtl/ppmdec_sync.sv
module ppmdec_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ppmdec_glitch.sv
module ppmdec_glitch (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic prev_q;
    logic out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            prev_q <= din;
            if (din == prev_q) out_q <= din;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/ppmdec_edge.sv
module ppmdec_edge
    import ppmdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    output edge_info_t edges
);
    logic lvl_d;

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b0;
        else     lvl_d <= lvl;
    end

    always_comb begin
        edges.rise = lvl & ~lvl_d;
        edges.fall = ~lvl & lvl_d;
    end
endmodule

// File: rtl/ppmdec_symbol_fsm.sv
module ppmdec_symbol_fsm
    import ppmdec_pkg::*;
#(
    parameter int unsigned LEAD_TICKS    = 32,
    parameter int unsigned NIB_W         = 4,
    parameter int unsigned MIN_GAP_TICKS = 32,
    parameter int unsigned TIMEOUT_TICKS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  edge_info_t  edges,
    output sym_result_t result
);
    localparam int unsigned SPAN  = 1 << NIB_W;
    localparam int unsigned CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam int unsigned GAP_W = $clog2(MIN_GAP_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TIMEOUT_TICKS);
    localparam logic [GAP_W-1:0] GAP_LIMIT = GAP_W'(MIN_GAP_TICKS);
    localparam logic [CNT_W-1:0] CNT_LEAD  = CNT_W'(LEAD_TICKS);

    sym_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [GAP_W-1:0] gap;
    logic [CNT_W-1:0] offset;

    assign offset = cnt - CNT_LEAD;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            gap        <= '0;
            result.ev  <= EV_NONE;
            result.nib <= '0;
        end else begin
            result.ev <= EV_NONE;
            case (state)
                ST_IDLE: begin
                    if (edges.rise) begin
                        state <= ST_MEAS;
                        cnt   <= CNT_W'(1);
                    end
                end
                ST_MEAS: begin
                    if (edges.fall) begin
                        state <= ST_GAP;
                        gap   <= GAP_W'(1);
                        if (count_in_window(int'(cnt), LEAD_TICKS, SPAN)) begin
                            result.ev  <= EV_NIBBLE;
                            result.nib <= offset[NIB_W-1:0];
                        end else begin
                            result.ev <= EV_RANGE;
                        end
                    end else if (cnt == CNT_LIMIT) begin
                        result.ev <= EV_TIMEOUT;
                        state     <= ST_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_GAP: begin
                    if (edges.rise) begin
                        if (gap < GAP_LIMIT) result.ev <= EV_SPACING;
                        state <= ST_MEAS;
                        cnt   <= CNT_W'(1);
                    end else if (gap < GAP_LIMIT) begin
                        gap <= gap + GAP_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ppm_nibble_decoder.sv
module ppm_nibble_decoder
    import ppmdec_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned LEAD_TICKS    = 32,
    parameter int unsigned MIN_GAP_TICKS = 32,
    parameter int unsigned TIMEOUT_TICKS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_in,
    output logic       nib_valid,
    output logic [3:0] nib_data,
    output logic       err_range,
    output logic       err_timeout,
    output logic       err_spacing
);
    localparam int unsigned NIB_W = 4;

    logic        synced;
    logic        filtered;
    edge_info_t  edges;
    sym_result_t result;

    ppmdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rd_in),
        .dout(synced)
    );

    ppmdec_glitch u_glitch (
        .clk (clk),
        .rst (rst),
        .din (synced),
        .dout(filtered)
    );

    ppmdec_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (filtered),
        .edges(edges)
    );

    ppmdec_symbol_fsm #(
        .LEAD_TICKS   (LEAD_TICKS),
        .NIB_W        (NIB_W),
        .MIN_GAP_TICKS(MIN_GAP_TICKS),
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .edges (edges),
        .result(result)
    );

    assign nib_valid   = (result.ev == EV_NIBBLE);
    assign err_range   = (result.ev == EV_RANGE);
    assign err_timeout = (result.ev == EV_TIMEOUT);
    assign err_spacing = (result.ev == EV_SPACING);
    assign nib_data    = result.nib;
endmodule

// File: rtl/ppm_nibble_decoder_chk.sv
module ppm_nibble_decoder_chk #(
    parameter int unsigned LAT = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       rd_in,
    input logic       nib_valid,
    input logic [3:0] nib_data,
    input logic       err_range,
    input logic       err_timeout,
    input logic       err_spacing
);
    // R8: outcomes never overlap
    p_single_outcome_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nib_valid, err_range, err_timeout, err_spacing}));

    // R8: strobes last one cycle
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        nib_valid |=> !nib_valid);

    // R2: nibble held between strobes
    p_nib_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !nib_valid |-> $stable(nib_data));

    // R2: a nibble follows a sampled falling edge LAT edges earlier
    p_valid_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
        nib_valid |-> !$past(rd_in, LAT));

    // R3: a range error also follows a falling edge
    p_range_after_fall_r3: assert property (@(posedge clk) disable iff (rst)
        err_range |-> !$past(rd_in, LAT));

    // R4: a timeout means the line was still high
    p_timeout_high_r4: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> $past(rd_in, LAT));

    // R5: a spacing error is tied to a sampled start edge
    p_spacing_on_start_r5: assert property (@(posedge clk) disable iff (rst)
        err_spacing |-> $past(rd_in, LAT));

    // R1: quiet right after reset release
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> !(nib_valid || err_range || err_timeout || err_spacing));
endmodule

bind ppm_nibble_decoder ppm_nibble_decoder_chk #(.LAT(SYNC_STAGES + 3)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_in      (rd_in),
    .nib_valid  (nib_valid),
    .nib_data   (nib_data),
    .err_range  (err_range),
    .err_timeout(err_timeout),
    .err_spacing(err_spacing)
);

// File: tb/sim_ppm_nibble_decoder.sv
`timescale 1ns/1ps
module sim_ppm_nibble_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_in = 1'b0;
    logic       nib_valid;
    logic [3:0] nib_data;
    logic       err_range;
    logic       err_timeout;
    logic       err_spacing;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    // expected schedule: kind 1 nibble, 2 range, 3 timeout, 4 spacing
    int    exp_kind [int];
    int    exp_val  [int];
    string exp_req  [int];
    int    last_val = 0;
    bit    last_had_fall = 1'b0;
    int    last_gap = 0;

    always #10 clk = ~clk;

    ppm_nibble_decoder u0 (
        .clk(clk), .rst(rst), .rd_in(rd_in),
        .nib_valid(nib_valid), .nib_data(nib_data),
        .err_range(err_range), .err_timeout(err_timeout),
        .err_spacing(err_spacing)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    // reference comparison on every clock
    always @(negedge clk) begin
        if (checking) begin
            int k;
            string rq;
            int act;
            int expv;
            k  = exp_kind.exists(cyc) ? exp_kind[cyc] : 0;
            rq = exp_req.exists(cyc) ? exp_req[cyc] : "R8";
            act  = {28'd0, nib_valid, err_range, err_timeout, err_spacing};
            expv = (k == 1) ? 8 : (k == 2) ? 4 : (k == 3) ? 2 : (k == 4) ? 1 : 0;
            check(act == expv, rq, act, expv);
            if (k == 1) last_val = exp_val[cyc];
            check(int'(nib_data) == last_val, (k == 1) ? rq : "R2", int'(nib_data), last_val);
        end
    end

    task automatic drive(input bit v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_in = v;
        end
    endtask

    // one symbol: D high samples, then L low samples
    task automatic sym(input int d, input int l, input string req);
        int a;
        @(negedge clk);
        a = cyc + 1;
        rd_in = 1'b1;
        if (last_had_fall && last_gap < 32) begin
            exp_kind[a + 4] = 4;
            exp_req[a + 4]  = "R5";
        end
        if (d >= 32 && d <= 47) begin
            exp_kind[a + d + 4] = 1;
            exp_val[a + d + 4]  = d - 32;
            exp_req[a + d + 4]  = req;
        end else if (d <= 64) begin
            exp_kind[a + d + 4] = 2;
            exp_req[a + d + 4]  = req;
        end else begin
            exp_kind[a + 68] = 3;
            exp_req[a + 68]  = req;
        end
        drive(1'b1, d - 1);
        drive(1'b0, l);
        last_had_fall = (d <= 64);
        last_gap = l;
    endtask

    initial begin
        while (!done && cyc < 100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({nib_valid, err_range, err_timeout, err_spacing, nib_data} == 8'd0, "R1",
              int'({nib_valid, err_range, err_timeout, err_spacing, nib_data}), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        checking = 1'b1;
        drive(1'b0, 20);   // R1: idle after release, compared each cycle

        // R2, R6, R9: every value, minimum legal gap
        for (int d = 32; d <= 47; d++) sym(d, 32, "R2");
        // R6: long gap
        sym(40, 500, "R6");
        sym(33, 40, "R6");
        // R3: below and above window
        sym(31, 40, "R3");
        sym(20, 40, "R3");
        sym(48, 40, "R3");
        sym(64, 40, "R3");
        // R4: timeout, next start not spacing-checked
        sym(65, 40, "R4");
        sym(70, 5, "R4");
        sym(36, 40, "R4");
        // R5: short gaps, still decoded
        sym(40, 10, "R5");
        sym(35, 31, "R5");
        sym(44, 32, "R5");
        sym(39, 40, "R6");
        sym(20, 5, "R5");
        sym(45, 40, "R5");
        // R7: one-tick high on idle line
        drive(1'b1, 1);
        drive(1'b0, 40);
        last_gap += 41;
        // R7: one-tick dip inside high time, 40 samples total
        begin
            int a;
            @(negedge clk);
            a = cyc + 1;
            rd_in = 1'b1;
            exp_kind[a + 44] = 1;
            exp_val[a + 44]  = 8;
            exp_req[a + 44]  = "R7";
            drive(1'b1, 9);
            drive(1'b0, 1);
            drive(1'b1, 29);
            drive(1'b0, 40);
            last_had_fall = 1'b1;
            last_gap = 40;
        end
        sym(47, 40, "R2");
        drive(1'b0, 20);
        checking = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule